// File: doc/BRIEF.md
# Cross-Clock Counter Read Synchronizer

This block holds a free-running 32-bit counter that runs in its own peripheral clock domain. An APB-style bus reads the counter from a separate bus clock domain. The bus never samples the live counter. It sees a shadow copy kept in the bus domain, and that copy is refreshed only by a full toggle handshake across both domains. The handshake takes its full cost even when the two clocks are the same signal. The counter value is latched into a holding register in the counter domain. It is released to the bus side only after it has been stable for several counter cycles.

Software has three ways to get a value. A plain read of the count register with a stale shadow holds PREADY low until a new value arrives. A write of the request bit starts a transfer without holding the bus, and software then polls the busy flag. The continuous bit makes the block start a new transfer after each one completes, so reads never wait once the first value has landed. The bus-side controller is a three-state machine. In `XS_IDLE` no transfer is outstanding. In `XS_WAIT` a transfer is in flight and no read is held. In `XS_STALL` a transfer is in flight and a count read is held.

The transitions are as follows:
- `XS_IDLE` goes to `XS_STALL` on a stale count read, or to `XS_WAIT` on a request write or while continuous mode is on.
- `XS_WAIT` goes to `XS_STALL` when a stale count read arrives.
- `XS_WAIT` goes to `XS_IDLE` when the transfer lands, or stays in `XS_WAIT` and launches again in continuous mode.
- `XS_STALL` goes to `XS_IDLE` or `XS_WAIT` in the cycle the held read is released.

Top module: `xdr_count_reader`

## Requirements
- R1: The counter advances once per counter-clock cycle, or once per 2^PRESC_LOG2 cycles when PRESC_LOG2 > 0. A returned count lies between the counter value when the read or request began and the value when the data was returned.
- R2: After reset, the control word (offset 0x0) and the status word (offset 0x4) both read 0, and neither read waits.
- R3: A read of the count word (offset 0x8) while the shadow is not valid holds PREADY low until a transfer lands, and then returns the fresh value. No other access ever sees PREADY low.
- R4: A held read lasts D bus cycles, with 5·Tcnt + 2·Tbus ≤ D·Tbus ≤ 6·Tcnt + 3·Tbus. With identical, edge-aligned clocks, D is exactly 9.
- R5: Writing 1 to control bit 0 starts a transfer with no wait state. Status bit 0 (busy) is then 1 until the value lands and 0 afterwards. A count read after busy clears completes with no wait state.
- R6: With control bit 1 clear, a completed count read uses up the shadow. Status bit 1 (valid) then reads 0, and the next count read is held again.
- R7: With control bit 1 set, the block restarts a transfer after each one lands. Once status bit 1 is 1, count reads take no wait state and return non-decreasing values.
- R8: Writes and reads of the control or status word complete in their first access cycle, and PSLVERR stays 0.
- R9: Control bit 1 reads back the continuous setting, and control bit 0 reads 0. Writes to the status or count word have no effect. Offsets other than 0x0, 0x4 and 0x8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low, asynchronous |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the word |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Low only while a count read is held |
| pslverr | output | 1 | Error response, always 0 |
| cnt_clk | input | 1 | Counter-domain clock |
| cnt_rst_n | input | 1 | Counter-domain reset, active low, asynchronous |

## Verification
The hardest points to reach are a held read that finishes in the same cycle the acknowledge toggle appears, and a measured hold time that sits near either edge of its bound. To reach them, the stimulus first runs with the two clocks identical and edge-aligned, where the hold length is fixed at nine cycles. It then switches the counter clock to a period twenty-one times longer at an arbitrary phase. Seeded random gaps and a random choice between plain reads and request-then-poll reads then move the transfers across many phase offsets between the two clock edges.

// File: rtl/xdr_pkg.sv
package xdr_pkg;

    // Bus-side controller states
    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_WAIT  = 2'd1,
        XS_STALL = 2'd2
    } xs_state_e;

    // Counter-domain delay between capture and acknowledge; fixes the
    // latency window and gives the held value time to settle
    localparam int unsigned XDR_ACK_STAGES = 3;

    // Word offsets
    localparam int unsigned XDR_OFF_CTRL = 0;
    localparam int unsigned XDR_OFF_STAT = 4;
    localparam int unsigned XDR_OFF_CNT  = 8;

endpackage

// File: rtl/xdr_sync.sv
module xdr_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/xdr_counter.sv
module xdr_counter #(
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned PRESC_LOG2 = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);

    logic tick;

    generate
        if (PRESC_LOG2 == 0) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            logic [PRESC_LOG2-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_q + 1'b1;
            end
            assign tick = &pre_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count + 1'b1;
    end

endmodule

// File: rtl/xdr_capture.sv
module xdr_capture
    import xdr_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tog_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] hold_o,
    output logic             ack_tog_o
);

    logic                      req_s;
    logic                      req_seen_q;
    logic [XDR_ACK_STAGES-1:0] ack_pipe_q;

    xdr_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tog_i),
        .q     (req_s)
    );

    // Latch the count on each new request edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_seen_q <= 1'b0;
            hold_o     <= '0;
        end else if (req_s != req_seen_q) begin
            req_seen_q <= req_s;
            hold_o     <= count_i;
        end
    end

    // Acknowledge trails the capture so the held word is settled first
    generate
        if (XDR_ACK_STAGES == 1) begin : g_ack1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ack_pipe_q <= '0;
                else        ack_pipe_q <= req_seen_q;
            end
        end else begin : g_ackn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ack_pipe_q <= '0;
                else        ack_pipe_q <= {ack_pipe_q[XDR_ACK_STAGES-2:0], req_seen_q};
            end
        end
    endgenerate

    assign ack_tog_o = ack_pipe_q[XDR_ACK_STAGES-1];

endmodule

// File: rtl/xdr_count_reader.sv
module xdr_count_reader
    import xdr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned PRESC_LOG2  = 0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              cnt_clk,
    input  logic              cnt_rst_n
);

    localparam int unsigned DATA_W = 32;

    // Counter domain
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] hold_w;
    logic             ack_tog_w;

    // Bus domain state
    xs_state_e        state_q, state_d;
    logic             req_tog_q;
    logic             ack_s;
    logic             ack_seen_q;
    logic             valid_q;
    logic             cont_en_q;
    logic [CNT_W-1:0] shadow_q;

    // Bus decode
    logic acc, wr_acc, rd_acc;
    logic sel_ctrl, sel_stat, sel_cnt;
    logic acc_cnt, req_cmd, ack_new, fresh, stall_rd, cnt_rd_done, launch;
    logic busy;
    logic unused_wdata;

    xdr_counter #(.CNT_W(CNT_W), .PRESC_LOG2(PRESC_LOG2)) u_counter (
        .clk   (cnt_clk),
        .rst_n (cnt_rst_n),
        .count (count_w)
    );

    xdr_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk       (cnt_clk),
        .rst_n     (cnt_rst_n),
        .req_tog_i (req_tog_q),
        .count_i   (count_w),
        .hold_o    (hold_w),
        .ack_tog_o (ack_tog_w)
    );

    xdr_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_ack_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .d     (ack_tog_w),
        .q     (ack_s)
    );

    assign acc         = psel & penable;
    assign wr_acc      = acc & pwrite;
    assign rd_acc      = acc & ~pwrite;
    assign sel_ctrl    = (paddr == ADDR_W'(XDR_OFF_CTRL));
    assign sel_stat    = (paddr == ADDR_W'(XDR_OFF_STAT));
    assign sel_cnt     = (paddr == ADDR_W'(XDR_OFF_CNT));
    assign acc_cnt     = rd_acc & sel_cnt;
    assign req_cmd     = wr_acc & sel_ctrl & pwdata[0];
    assign ack_new     = ack_s ^ ack_seen_q;
    assign fresh       = valid_q | ack_new;
    assign stall_rd    = acc_cnt & ~fresh;
    assign cnt_rd_done = acc_cnt & fresh;
    assign unused_wdata = ^pwdata[DATA_W-1:2];

    // Next state and launch decision
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            XS_IDLE: begin
                if (stall_rd) begin
                    launch  = 1'b1;
                    state_d = XS_STALL;
                end else if (req_cmd | cont_en_q) begin
                    launch  = 1'b1;
                    state_d = XS_WAIT;
                end
            end
            XS_WAIT: begin
                if (ack_new) begin
                    if (cont_en_q | req_cmd) launch  = 1'b1;
                    else                     state_d = XS_IDLE;
                end else if (stall_rd) begin
                    state_d = XS_STALL;
                end
            end
            XS_STALL: begin
                if (ack_new) begin
                    if (cont_en_q) begin
                        launch  = 1'b1;
                        state_d = XS_WAIT;
                    end else begin
                        state_d = XS_IDLE;
                    end
                end
            end
            default: state_d = XS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) state_q <= XS_IDLE;
        else          state_q <= state_d;
    end

    // Handshake, shadow and control storage
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            req_tog_q  <= 1'b0;
            ack_seen_q <= 1'b0;
            valid_q    <= 1'b0;
            cont_en_q  <= 1'b0;
            shadow_q   <= '0;
        end else begin
            if (launch) req_tog_q <= ~req_tog_q;
            if (ack_new) begin
                ack_seen_q <= ack_s;
                shadow_q   <= hold_w;
            end
            if (cnt_rd_done & ~cont_en_q) valid_q <= 1'b0;
            else if (ack_new)             valid_q <= 1'b1;
            if (wr_acc & sel_ctrl) cont_en_q <= pwdata[1];
        end
    end

    // Outputs
    always_comb begin
        busy    = (state_q != XS_IDLE);
        pready  = ~stall_rd;
        pslverr = 1'b0;
        prdata  = '0;
        if (sel_ctrl) begin
            prdata[1] = cont_en_q;
        end else if (sel_stat) begin
            prdata[0] = busy;
            prdata[1] = valid_q;
        end else if (sel_cnt) begin
            prdata = DATA_W'(ack_new ? hold_w : shadow_q);
        end
    end

endmodule

// File: rtl/xdr_count_reader_chk.sv
module xdr_count_reader_chk
    import xdr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              pready,
    input logic              valid_q,
    input logic              cont_en_q,
    input logic              ack_s,
    input logic              ack_seen_q,
    input xs_state_e         state_q
);

    logic cnt_rd;
    assign cnt_rd = psel && penable && !pwrite && (paddr == ADDR_W'(XDR_OFF_CNT));

    assert_write_nowait_R8: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite) |-> pready);

    assert_hold_only_count_R3: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pready) |-> (!pwrite && paddr == ADDR_W'(XDR_OFF_CNT)));

    assert_stall_state_bus_R3: assert property (@(posedge pclk) disable iff (!presetn)
        (state_q == XS_STALL) |-> cnt_rd);

    assert_release_on_ack_R4: assert property (@(posedge pclk) disable iff (!presetn)
        (cnt_rd && pready && $past(psel && penable && !pready)) |-> (ack_s != ack_seen_q));

    assert_read_consumes_R6: assert property (@(posedge pclk) disable iff (!presetn)
        (cnt_rd && pready && !cont_en_q) |=> !valid_q);

    assert_cont_nowait_R7: assert property (@(posedge pclk) disable iff (!presetn)
        (cnt_rd && cont_en_q && valid_q) |-> pready);

endmodule

bind xdr_count_reader xdr_count_reader_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_xdr_count_reader.sv
module sim_xdr_count_reader;

    localparam int PA = 8;

    logic        pclk = 1'b0;
    logic        cclk = 1'b0;
    logic        presetn = 1'b0;
    logic        crst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [31:0] ref_cnt;

    int chalf  = 4;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 pclk = ~pclk;
    always #(chalf) cclk = ~cclk;

    // Reference counter, advancing once per counter clock
    always @(posedge cclk or negedge crst_n)
        if (!crst_n) ref_cnt <= '0;
        else         ref_cnt <= ref_cnt + 1;

    xdr_count_reader u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .cnt_clk(cclk), .cnt_rst_n(crst_n)
    );

    function automatic longint lo_ns(input int pg, input int pa);
        return 5 * pg + 2 * pa;
    endfunction

    function automatic longint hi_ns(input int pg, input int pa);
        return 6 * pg + 3 * pa;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic apb_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        check(pready == 1'b1, "R8 write wait state", pready, 1);
        check(pslverr == 1'b0, "R8 write error", pslverr, 0);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [3:0] a, output logic [31:0] d, output int st,
                            output logic [31:0] r0, output logic [31:0] r1);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        st = 0;
        r0 = ref_cnt;
        while (!pready) begin
            st++;
            @(negedge pclk);
            #1;
        end
        d  = prdata;
        r1 = ref_cnt;
        check(pslverr == 1'b0, "R8 read error", pslverr, 0);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic poll_stat(input int bitn, input logic want, output int n);
        logic [31:0] d, a0, a1;
        int st;
        n = 0;
        do begin
            apb_read(4'h4, d, st, a0, a1);
            n++;
        end while (d[bitn] !== want && n < 3000);
    endtask

    // Plain read with stale shadow: held, bounded, bracketed
    task automatic direct_read(input bit exact9, input int pg);
        logic [31:0] d, r0, r1;
        int st;
        longint dns;
        apb_read(4'h8, d, st, r0, r1);
        dns = longint'(st) * PA;
        check(st > 0, "R3 stale read not held", st, 1);
        check(d >= r0 && d <= r1, "R1 value outside capture window", d, r0);
        check(dns >= lo_ns(pg, PA) && dns <= hi_ns(pg, PA), "R4 hold time out of bound", dns, lo_ns(pg, PA));
        if (exact9) check(st == 9, "R4 aligned hold length", st, 9);
    endtask

    // Request, poll busy, then read without wait
    task automatic request_read();
        logic [31:0] d, r0, r1, w0;
        int st, n;
        w0 = ref_cnt;
        apb_write(4'h0, 32'h1);
        apb_read(4'h4, d, st, r0, r1);
        check(d[0] == 1'b1, "R5 busy after request", d[0], 1);
        poll_stat(0, 1'b0, n);
        check(n < 3000, "R5 busy never cleared", n, 0);
        apb_read(4'h4, d, st, r0, r1);
        check(d[1] == 1'b1, "R5 valid after transfer", d[1], 1);
        apb_read(4'h8, d, st, r0, r1);
        check(st == 0, "R5 read after poll waited", st, 0);
        check(d >= w0 && d <= r1, "R1 requested value outside window", d, w0);
        apb_read(4'h4, d, st, r0, r1);
        check(d[1] == 1'b0, "R6 shadow not consumed", d[1], 0);
    endtask

    task automatic cont_phase(input int reads, input bit lag_check);
        logic [31:0] d, r0, r1, prev;
        int st, n;
        apb_write(4'h0, 32'h2);
        apb_read(4'h0, d, st, r0, r1);
        check(d == 32'h2, "R9 control readback", d, 2);
        poll_stat(1, 1'b1, n);
        check(n < 3000, "R7 valid never set", n, 0);
        prev = '0;
        for (int i = 0; i < reads; i++) begin
            repeat ($urandom_range(0, 15)) @(negedge pclk);
            apb_read(4'h8, d, st, r0, r1);
            check(st == 0, "R7 continuous read waited", st, 0);
            check(d >= prev && d <= r1, "R7 value order", d, prev);
            if (lag_check) check(d + 40 >= r1, "R7 shadow not refreshing", d, r1);
            prev = d;
        end
        apb_write(4'h0, 32'h0);
        poll_stat(0, 1'b0, n);
        apb_read(4'h8, d, st, r0, r1);
    endtask

    initial begin
        logic [31:0] d, r0, r1;
        int st;
        void'($urandom(32'd1311));
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        crst_n  = 1'b1;
        repeat (4) @(negedge pclk);

        // R2: reset state
        apb_read(4'h0, d, st, r0, r1);
        check(d == 32'h0, "R2 control after reset", d, 0);
        check(st == 0, "R8 control read waited", st, 0);
        apb_read(4'h4, d, st, r0, r1);
        check(d == 32'h0, "R2 status after reset", d, 0);
        check(st == 0, "R2 status read waited", st, 0);

        // Equal, aligned clocks
        direct_read(1'b1, 2 * chalf);
        apb_read(4'h4, d, st, r0, r1);
        check(d[1] == 1'b0, "R6 valid after plain read", d[1], 0);
        direct_read(1'b1, 2 * chalf);
        request_read();

        // R9: ignored writes and unmapped offset
        apb_write(4'h8, 32'hFFFF_0000);
        apb_write(4'h4, 32'h3);
        apb_read(4'h4, d, st, r0, r1);
        check(d == 32'h0, "R9 status write changed state", d, 0);
        apb_read(4'hC, d, st, r0, r1);
        check(d == 32'h0, "R9 unmapped offset", d, 0);
        direct_read(1'b1, 2 * chalf);

        cont_phase(8, 1'b1);

        // Widely mismatched clocks
        chalf = 84;
        repeat (40) @(negedge pclk);
        for (int i = 0; i < 10; i++) begin
            repeat ($urandom_range(0, 20)) @(negedge pclk);
            if ($urandom_range(0, 1) == 0) direct_read(1'b0, 2 * chalf);
            else                          request_read();
        end
        cont_phase(4, 1'b0);
        direct_read(1'b0, 2 * chalf);

        summary();
    end

    initial begin
        repeat (150000) @(posedge pclk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

endmodule